// File: doc/BRIEF.md
# SCSI Host DMA Channel Controller

This block is the DMA engine of a SCSI host adapter. It is programmed through eight 32-bit registers, reached by a 3-bit index. Software loads a starting byte count, a starting memory address and a starting descriptor address. It then writes the command register to start, stop or abort the channel. Writing the start opcode copies the three starting values into working registers, wipes the status flags and arms the channel.

While the channel is armed, the SCSI core asks for data movement one chunk at a time through a transfer-request port. Each request carries a byte length and a direction. The block trims the chunk to the bytes still owed and raises a single memory request, which is held under a valid/ready handshake. It then moves the working count down and the working address up by the trimmed length. When the count reaches zero, or the core reports that its command has finished, the done flag is raised.

The sticky status flags can be cleared in one of two ways, picked by a separate bus-control bit. In one mode, software writes ones over the flags to clear them. In the other mode, reading the status register clears them.

Top module: `scsi_dma_chan`

## Requirements
- R1: Reset leaves the command register at 0, the working count at 0, the working address at 0xFFFFFFFF, the working descriptor at 0xFFFFFFFD, status at 0, the channel disarmed, no memory request pending and the transfer port ready.
- R2: A command write whose bits 1:0 equal 3 (start) copies index 1 into index 3, index 2 into index 4 and index 6 into index 7, clears all six status bits and arms the channel on the next cycle. Register indices: 0 command, 1 start count, 2 start address, 3 working count, 4 working address, 5 status, 6 start descriptor, 7 working descriptor.
- R3: Opcode 0 (idle) disarms the channel, and transfers are then dropped. Opcode 1 (blast) changes neither the armed state nor the working registers.
- R4: Opcode 2 (abort) raises the cancel output for exactly the cycle of the command write. No other write raises it.
- R5: With the clear-on-read select at 0, a status write clears bits 1, 2 and 3 (error, abort, done) wherever the data holds a 1. Other bits and zero data bits leave status unchanged.
- R6: With the clear-on-read select at 1, status writes are ignored, and a status read returns the flags and then clears bits 1 to 3.
- R7: Status reads return bit 4 set whenever the core interrupt input is high. This bit is never stored.
- R8: A transfer request made while the channel is disarmed, or whose direction differs from command bit 7 (1 = device to memory), makes no memory request and leaves the working count and address unchanged.
- R9: An accepted transfer issues a memory request. The request carries the working address, the smaller of the requested length and the working count, and the request direction. The working count falls by that length and the working address rises by it.
- R10: Status bit 3 (done) is set when a transfer brings the working count to 0.
- R11: A pulse on the command-complete input forces the working count to 0 and sets done.
- R12: Writes to indices 3, 4 and 7 are ignored.
- R13: A memory request holds its valid, address and length until ready is seen. The transfer port shows not-ready while a request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en_i | input | 1 | Register write strobe |
| reg_rd_en_i | input | 1 | Register read strobe (for clear-on-read) |
| reg_idx_i | input | 3 | Register index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_idx_i, available in the same cycle |
| stat_clr_on_read_i | input | 1 | Bus-control select: 1 = status clears on read, 0 = write-one-to-clear |
| core_irq_i | input | 1 | Interrupt level from the SCSI core |
| cmd_complete_i | input | 1 | Pulse: the SCSI command has completed |
| abort_req_o | output | 1 | Cancel request to the SCSI core |
| dma_active_o | output | 1 | Channel is armed |
| xfer_valid_i | input | 1 | Transfer request from the core |
| xfer_len_i | input | LEN_W | Requested chunk length in bytes |
| xfer_to_mem_i | input | 1 | Request direction, 1 = device to memory |
| xfer_ready_o | output | 1 | Transfer port can accept |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory request accepted |
| mem_req_addr_o | output | 32 | Memory request address |
| mem_req_len_o | output | LEN_W | Memory request length |
| mem_req_to_mem_o | output | 1 | Memory request direction |

## Verification
The bench drives a chunk larger than the remaining count and checks that the issued length is trimmed. A design that skipped the trim would overrun the buffer and wrap the count around instead of flagging done. It holds a memory request without ready while a second transfer is offered. A design that dropped the hold would lose the second chunk's place or emit two requests. Both clear modes are covered, including a write while clear-on-read is selected, which a design that honours it would clear too early. The live interrupt bit is read and then read again after the input drops, to catch a design that latched it into the stored status.

// File: rtl/scsi_dma_pkg.sv
package scsi_dma_pkg;
  localparam int REG_W = 32;
  localparam int IDX_W = 3;
  localparam int ST_W  = 6;

  localparam logic [IDX_W-1:0] IDX_CMD   = 3'd0;
  localparam logic [IDX_W-1:0] IDX_SCNT  = 3'd1;
  localparam logic [IDX_W-1:0] IDX_SADDR = 3'd2;
  localparam logic [IDX_W-1:0] IDX_WCNT  = 3'd3;
  localparam logic [IDX_W-1:0] IDX_WADDR = 3'd4;
  localparam logic [IDX_W-1:0] IDX_STAT  = 3'd5;
  localparam logic [IDX_W-1:0] IDX_SDESC = 3'd6;
  localparam logic [IDX_W-1:0] IDX_WDESC = 3'd7;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_BLAST = 2'd1,
    OP_ABORT = 2'd2,
    OP_START = 2'd3
  } dma_op_e;

  localparam int CMD_DIR_BIT = 7;
  localparam int ST_DONE_BIT = 3;
  localparam int ST_SINT_BIT = 4;
  localparam logic [ST_W-1:0] ST_STICKY_MASK = 6'b00_1110;

  localparam logic [REG_W-1:0] WADDR_RST = 32'hFFFF_FFFF;
  localparam logic [REG_W-1:0] WDESC_RST = 32'hFFFF_FFFD;

  // Applies the two clear rules to the stored flags.
  function automatic logic [ST_W-1:0] stat_after_clear(
      input logic [ST_W-1:0] cur, input logic w1c_hit,
      input logic [ST_W-1:0] wbits, input logic cor_hit);
    logic [ST_W-1:0] r;
    r = cur;
    if (w1c_hit) r = r & ~(wbits & ST_STICKY_MASK);
    if (cor_hit) r = r & ~ST_STICKY_MASK;
    return r;
  endfunction
endpackage

// File: rtl/scsi_dma_ctrl.sv
module scsi_dma_ctrl
  import scsi_dma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             clr_on_read_i,
  input  logic             done_evt_i,
  output logic [REG_W-1:0] cmd_q,
  output logic [REG_W-1:0] scnt_q,
  output logic [REG_W-1:0] saddr_q,
  output logic [REG_W-1:0] sdesc_q,
  output logic [ST_W-1:0]  stat_q,
  output logic             active_q,
  output logic             start_evt_o,
  output logic             idle_evt_o,
  output logic             abort_evt_o
);
  logic    cmd_wr;
  dma_op_e op;
  logic    w1c_hit, cor_hit;
  logic [ST_W-1:0] stat_n;

  assign cmd_wr      = wr_en_i && (idx_i == IDX_CMD);
  assign op          = dma_op_e'(wdata_i[1:0]);
  assign start_evt_o = cmd_wr && (op == OP_START);
  assign idle_evt_o  = cmd_wr && (op == OP_IDLE);
  assign abort_evt_o = cmd_wr && (op == OP_ABORT);

  assign w1c_hit = wr_en_i && (idx_i == IDX_STAT) && !clr_on_read_i;
  assign cor_hit = rd_en_i && (idx_i == IDX_STAT) && clr_on_read_i;

  always_comb begin
    stat_n = stat_after_clear(stat_q, w1c_hit, wdata_i[ST_W-1:0], cor_hit);
    if (done_evt_i) stat_n[ST_DONE_BIT] = 1'b1;
    if (start_evt_o) stat_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      scnt_q   <= '0;
      saddr_q  <= '0;
      sdesc_q  <= '0;
      stat_q   <= '0;
      active_q <= 1'b0;
    end else begin
      stat_q <= stat_n;
      if (wr_en_i) begin
        case (idx_i)
          IDX_CMD:   cmd_q   <= wdata_i;
          IDX_SCNT:  scnt_q  <= wdata_i;
          IDX_SADDR: saddr_q <= wdata_i;
          IDX_SDESC: sdesc_q <= wdata_i;
          default: ;
        endcase
      end
      if (start_evt_o)     active_q <= 1'b1;
      else if (idle_evt_o) active_q <= 1'b0;
    end
  end
endmodule

// File: rtl/scsi_dma_xfer.sv
module scsi_dma_xfer
  import scsi_dma_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_evt_i,
  input  logic [REG_W-1:0] scnt_i,
  input  logic [REG_W-1:0] saddr_i,
  input  logic [REG_W-1:0] sdesc_i,
  input  logic             active_i,
  input  logic             dir_to_mem_i,
  input  logic             cmd_complete_i,
  input  logic             xfer_valid_i,
  input  logic [LEN_W-1:0] xfer_len_i,
  input  logic             xfer_to_mem_i,
  output logic             xfer_ready_o,
  input  logic             mem_ready_i,
  output logic             mem_valid_o,
  output logic [REG_W-1:0] mem_addr_o,
  output logic [LEN_W-1:0] mem_len_o,
  output logic             mem_to_mem_o,
  output logic [REG_W-1:0] wcnt_q,
  output logic [REG_W-1:0] waddr_q,
  output logic [REG_W-1:0] wdesc_q,
  output logic             accept_evt_o,
  output logic             match_evt_o,
  output logic             done_evt_o
);
  localparam int PAD_W = REG_W - LEN_W;

  // Smaller of the request and the remaining count; fits LEN_W bits.
  function automatic logic [LEN_W-1:0] trim_chunk(
      input logic [LEN_W-1:0] req, input logic [REG_W-1:0] left);
    if ({{PAD_W{1'b0}}, req} <= left) return req;
    return left[LEN_W-1:0];
  endfunction

  logic [LEN_W-1:0] chunk;
  logic [REG_W-1:0] chunk_ext;
  logic [REG_W-1:0] wcnt_after;

  assign xfer_ready_o = !mem_valid_o;
  assign accept_evt_o = xfer_valid_i && xfer_ready_o;
  assign match_evt_o  = accept_evt_o && active_i && (xfer_to_mem_i == dir_to_mem_i);
  assign chunk        = trim_chunk(xfer_len_i, wcnt_q);
  assign chunk_ext    = {{PAD_W{1'b0}}, chunk};
  assign wcnt_after   = wcnt_q - chunk_ext;
  assign done_evt_o   = (match_evt_o && (wcnt_after == '0)) || cmd_complete_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q  <= '0;
      waddr_q <= WADDR_RST;
      wdesc_q <= WDESC_RST;
    end else begin
      if (match_evt_o) begin
        wcnt_q  <= wcnt_after;
        waddr_q <= waddr_q + chunk_ext;
      end
      if (cmd_complete_i) wcnt_q <= '0;
      if (start_evt_i) begin
        wcnt_q  <= scnt_i;
        waddr_q <= saddr_i;
        wdesc_q <= sdesc_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_valid_o  <= 1'b0;
      mem_addr_o   <= '0;
      mem_len_o    <= '0;
      mem_to_mem_o <= 1'b0;
    end else if (match_evt_o) begin
      mem_valid_o  <= 1'b1;
      mem_addr_o   <= waddr_q;
      mem_len_o    <= chunk;
      mem_to_mem_o <= xfer_to_mem_i;
    end else if (mem_ready_i) begin
      mem_valid_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/scsi_dma_chan.sv
module scsi_dma_chan
  import scsi_dma_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en_i,
  input  logic             reg_rd_en_i,
  input  logic [2:0]       reg_idx_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  input  logic             stat_clr_on_read_i,
  input  logic             core_irq_i,
  input  logic             cmd_complete_i,
  output logic             abort_req_o,
  output logic             dma_active_o,
  input  logic             xfer_valid_i,
  input  logic [LEN_W-1:0] xfer_len_i,
  input  logic             xfer_to_mem_i,
  output logic             xfer_ready_o,
  output logic             mem_req_valid_o,
  input  logic             mem_req_ready_i,
  output logic [31:0]      mem_req_addr_o,
  output logic [LEN_W-1:0] mem_req_len_o,
  output logic             mem_req_to_mem_o
);
  logic [REG_W-1:0] cmd_q, scnt_q, saddr_q, sdesc_q;
  logic [REG_W-1:0] wcnt_q, waddr_q, wdesc_q;
  logic [ST_W-1:0]  stat_q;
  logic             start_evt, idle_evt, abort_evt;
  logic             accept_evt, match_evt, done_evt;
  logic [ST_W-1:0]  stat_view;

  scsi_dma_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(reg_wr_en_i), .rd_en_i(reg_rd_en_i), .idx_i(reg_idx_i),
    .wdata_i(reg_wdata_i), .clr_on_read_i(stat_clr_on_read_i),
    .done_evt_i(done_evt),
    .cmd_q(cmd_q), .scnt_q(scnt_q), .saddr_q(saddr_q), .sdesc_q(sdesc_q),
    .stat_q(stat_q), .active_q(dma_active_o),
    .start_evt_o(start_evt), .idle_evt_o(idle_evt), .abort_evt_o(abort_evt)
  );

  scsi_dma_xfer #(.LEN_W(LEN_W)) u_xfer (
    .clk(clk), .rst_n(rst_n),
    .start_evt_i(start_evt), .scnt_i(scnt_q), .saddr_i(saddr_q), .sdesc_i(sdesc_q),
    .active_i(dma_active_o), .dir_to_mem_i(cmd_q[CMD_DIR_BIT]),
    .cmd_complete_i(cmd_complete_i),
    .xfer_valid_i(xfer_valid_i), .xfer_len_i(xfer_len_i), .xfer_to_mem_i(xfer_to_mem_i),
    .xfer_ready_o(xfer_ready_o),
    .mem_ready_i(mem_req_ready_i), .mem_valid_o(mem_req_valid_o),
    .mem_addr_o(mem_req_addr_o), .mem_len_o(mem_req_len_o), .mem_to_mem_o(mem_req_to_mem_o),
    .wcnt_q(wcnt_q), .waddr_q(waddr_q), .wdesc_q(wdesc_q),
    .accept_evt_o(accept_evt), .match_evt_o(match_evt), .done_evt_o(done_evt)
  );

  assign abort_req_o = abort_evt;

  always_comb begin
    stat_view = stat_q;
    if (core_irq_i) stat_view[ST_SINT_BIT] = 1'b1;
  end

  always_comb begin
    case (reg_idx_i)
      IDX_CMD:   reg_rdata_o = cmd_q;
      IDX_SCNT:  reg_rdata_o = scnt_q;
      IDX_SADDR: reg_rdata_o = saddr_q;
      IDX_WCNT:  reg_rdata_o = wcnt_q;
      IDX_WADDR: reg_rdata_o = waddr_q;
      IDX_STAT:  reg_rdata_o = {{(REG_W-ST_W){1'b0}}, stat_view};
      IDX_SDESC: reg_rdata_o = sdesc_q;
      default:   reg_rdata_o = wdesc_q;
    endcase
  end
endmodule

// File: rtl/scsi_dma_chan_chk.sv
module scsi_dma_chan_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_evt,
  input logic             idle_evt,
  input logic             accept_evt,
  input logic             match_evt,
  input logic             done_evt,
  input logic             cmd_complete_i,
  input logic [31:0]      scnt_q,
  input logic [31:0]      wcnt_q,
  input logic [5:0]       stat_q,
  input logic             dma_active_o,
  input logic             mem_req_valid_o,
  input logic             mem_req_ready_i,
  input logic [31:0]      mem_req_addr_o,
  input logic [LEN_W-1:0] mem_req_len_o
);
  assert_start_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> dma_active_o && (wcnt_q == $past(scnt_q)) && (stat_q == 6'd0));

  assert_idle_disarm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    idle_evt |=> !dma_active_o);

  assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o && !mem_req_ready_i |=>
      mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_len_o));

  assert_len_trim_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid_o) |-> ({{(32-LEN_W){1'b0}}, mem_req_len_o} <= $past(wcnt_q)));

  assert_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt && !match_evt && !start_evt && !cmd_complete_i |=>
      !mem_req_valid_o && $stable(wcnt_q));

  assert_done_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt && !start_evt |=> stat_q[3]);

  assert_complete_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_complete_i && !start_evt |=> (wcnt_q == 32'd0) && stat_q[3]);
endmodule

bind scsi_dma_chan scsi_dma_chan_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .start_evt(start_evt), .idle_evt(idle_evt),
  .accept_evt(accept_evt), .match_evt(match_evt), .done_evt(done_evt),
  .cmd_complete_i(cmd_complete_i),
  .scnt_q(scnt_q), .wcnt_q(wcnt_q), .stat_q(stat_q),
  .dma_active_o(dma_active_o),
  .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
  .mem_req_addr_o(mem_req_addr_o), .mem_req_len_o(mem_req_len_o)
);

// File: tb/scsi_dma_chan_tb.sv
module scsi_dma_chan_tb_top;
  localparam int LW = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]    idx = 3'd0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          cor = 1'b0, irq = 1'b0, cmpl = 1'b0;
  logic          abort_o, active_o;
  logic          xv = 1'b0, xdir = 1'b0;
  logic [LW-1:0] xlen = '0;
  logic          xrdy;
  logic          mv, mrdy = 1'b0, mdir;
  logic [31:0]   maddr;
  logic [LW-1:0] mlen;

  scsi_dma_chan #(.LEN_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en_i(wr_en), .reg_rd_en_i(rd_en), .reg_idx_i(idx),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .stat_clr_on_read_i(cor), .core_irq_i(irq), .cmd_complete_i(cmpl),
    .abort_req_o(abort_o), .dma_active_o(active_o),
    .xfer_valid_i(xv), .xfer_len_i(xlen), .xfer_to_mem_i(xdir), .xfer_ready_o(xrdy),
    .mem_req_valid_o(mv), .mem_req_ready_i(mrdy), .mem_req_addr_o(maddr),
    .mem_req_len_o(mlen), .mem_req_to_mem_o(mdir)
  );

  int    errs = 0;
  int    checks = 0;
  string tag = "R1";

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int unsigned m_cmd, m_scnt, m_saddr, m_sdesc, m_wcnt, m_waddr, m_wdesc;
  int unsigned m_stat, m_maddr, m_mlen;
  bit          m_act, m_mv, m_mdir;

  function automatic int unsigned model_read(input int i);
    case (i)
      0: return m_cmd;
      1: return m_scnt;
      2: return m_saddr;
      3: return m_wcnt;
      4: return m_waddr;
      5: return irq ? (m_stat | 32'h10) : m_stat;
      6: return m_sdesc;
      default: return m_wdesc;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    int unsigned take, n_wcnt, n_waddr, n_stat;
    bit go, n_mv, n_act;
    if (!rst_n) begin
      m_cmd = 0; m_scnt = 0; m_saddr = 0; m_sdesc = 0;
      m_wcnt = 0; m_waddr = 32'hFFFF_FFFF; m_wdesc = 32'hFFFF_FFFD;
      m_stat = 0; m_act = 0; m_mv = 0; m_maddr = 0; m_mlen = 0; m_mdir = 0;
    end else begin
      n_wcnt = m_wcnt; n_waddr = m_waddr; n_stat = m_stat; n_mv = m_mv; n_act = m_act;
      take = (xlen < m_wcnt) ? xlen : m_wcnt;
      go = xv && !m_mv && m_act && (xdir == m_cmd[7]);
      if (wr_en && idx == 5 && !cor) n_stat = n_stat & ~(wdata & 32'h0E);
      if (rd_en && idx == 5 && cor)  n_stat = n_stat & ~32'h0E;
      if (go) begin
        n_wcnt = m_wcnt - take;
        n_waddr = m_waddr + take;
        n_mv = 1; m_maddr = m_waddr; m_mlen = take; m_mdir = xdir;
        if (n_wcnt == 0) n_stat = n_stat | 32'h08;
      end else if (mrdy) n_mv = 0;
      if (cmpl) begin n_wcnt = 0; n_stat = n_stat | 32'h08; end
      if (wr_en && idx == 0) begin
        if (wdata[1:0] == 2'd0) n_act = 0;
        if (wdata[1:0] == 2'd3) begin
          n_act = 1; n_wcnt = m_scnt; n_waddr = m_saddr; m_wdesc = m_sdesc; n_stat = 0;
        end
      end
      if (wr_en) begin
        case (idx)
          3'd0: m_cmd = wdata;
          3'd1: m_scnt = wdata;
          3'd2: m_saddr = wdata;
          3'd6: m_sdesc = wdata;
          default: ;
        endcase
      end
      m_wcnt = n_wcnt; m_waddr = n_waddr; m_stat = n_stat; m_mv = n_mv; m_act = n_act;
    end
  end

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      chk(tag, "mem_valid", mv, m_mv);
      chk(tag, "xfer_ready", xrdy, !m_mv);
      chk(tag, "active", active_o, m_act);
      chk(tag, "abort", abort_o, wr_en && idx == 0 && wdata[1:0] == 2'd2);
      if (m_mv) begin
        chk(tag, "mem_addr", maddr, m_maddr);
        chk(tag, "mem_len", mlen, m_mlen);
        chk(tag, "mem_dir", mdir, m_mdir);
      end
      chk(tag, "rdata", rdata, model_read(idx));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [2:0] i, input logic [31:0] d);
    @(negedge clk); wr_en = 1; idx = i; wdata = d;
    @(negedge clk); wr_en = 0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] i, input logic [31:0] exp, input string req);
    @(negedge clk); rd_en = 1; idx = i;
    #1 chk(req, "read", rdata, exp);
    @(negedge clk); rd_en = 0;
  endtask

  task automatic xfer(input int len, input logic to_mem);
    @(negedge clk); xv = 1; xlen = LW'(len); xdir = to_mem;
    @(negedge clk); xv = 0;
  endtask

  task automatic ack();
    @(negedge clk); mrdy = 1;
    @(negedge clk); mrdy = 0;
  endtask

  initial begin : watchdog
    #(8 * 100000);
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 chk("R1", "active_in_reset", active_o, 0);
    chk("R1", "mem_valid_in_reset", mv, 0);
    rst_n = 1'b1;
    tag = "R1";
    rd(3'd3, 32'h0, "R1");
    rd(3'd4, 32'hFFFF_FFFF, "R1");
    rd(3'd7, 32'hFFFF_FFFD, "R1");
    rd(3'd5, 32'h0, "R1");
    rd(3'd0, 32'h0, "R1");
    #1 chk("R1", "xfer_ready", xrdy, 1);

    tag = "R2";
    wr(3'd1, 32'd100); wr(3'd2, 32'h1000); wr(3'd6, 32'h2000);
    wr(3'd0, 32'h83);
    rd(3'd3, 32'd100, "R2"); rd(3'd4, 32'h1000, "R2"); rd(3'd7, 32'h2000, "R2");
    #1 chk("R2", "armed", active_o, 1);

    tag = "R12";
    wr(3'd3, 32'd5); wr(3'd4, 32'd6); wr(3'd7, 32'd7);
    rd(3'd3, 32'd100, "R12"); rd(3'd4, 32'h1000, "R12"); rd(3'd7, 32'h2000, "R12");

    tag = "R13";
    xfer(40, 1'b1);
    #1 chk("R9", "req_addr", maddr, 32'h1000);
    chk("R9", "req_len", mlen, 40);
    chk("R13", "port_busy", xrdy, 0);
    xfer(8, 1'b1);
    repeat (2) @(negedge clk);
    #1 chk("R13", "still_valid", mv, 1);
    chk("R13", "addr_held", maddr, 32'h1000);
    ack();
    #1 chk("R13", "released", mv, 0);
    tag = "R9";
    rd(3'd3, 32'd60, "R9"); rd(3'd4, 32'h1028, "R9");

    tag = "R8";
    xfer(8, 1'b0);
    #1 chk("R8", "no_req_wrong_dir", mv, 0);
    rd(3'd3, 32'd60, "R8"); rd(3'd4, 32'h1028, "R8");

    tag = "R10";
    xfer(100, 1'b1);
    #1 chk("R9", "trimmed_len", mlen, 60);
    chk("R9", "trimmed_addr", maddr, 32'h1028);
    ack();
    rd(3'd3, 32'd0, "R10"); rd(3'd5, 32'h08, "R10");

    tag = "R5";
    wr(3'd5, 32'h04); rd(3'd5, 32'h08, "R5");
    wr(3'd5, 32'h08); rd(3'd5, 32'h00, "R5");

    tag = "R7";
    irq = 1; rd(3'd5, 32'h10, "R7");
    irq = 0; rd(3'd5, 32'h00, "R7");

    tag = "R11";
    wr(3'd0, 32'h83);
    rd(3'd3, 32'd100, "R11"); rd(3'd5, 32'h0, "R11");
    @(negedge clk); cmpl = 1; @(negedge clk); cmpl = 0;
    rd(3'd3, 32'd0, "R11"); rd(3'd5, 32'h08, "R11");

    tag = "R6";
    cor = 1;
    wr(3'd5, 32'h0E);
    rd(3'd5, 32'h08, "R6");
    rd(3'd5, 32'h00, "R6");
    cor = 0;

    tag = "R3";
    wr(3'd0, 32'h83);
    wr(3'd0, 32'h81);
    #1 chk("R3", "blast_keeps_armed", active_o, 1);
    rd(3'd3, 32'd100, "R3");
    wr(3'd0, 32'h80);
    #1 chk("R3", "idle_disarms", active_o, 0);
    xfer(4, 1'b1);
    #1 chk("R3", "idle_drops_xfer", mv, 0);
    rd(3'd3, 32'd100, "R3");

    tag = "R4";
    @(negedge clk); wr_en = 1; idx = 3'd0; wdata = 32'h82;
    #1 chk("R4", "abort_high", abort_o, 1);
    @(negedge clk); wr_en = 0; wdata = '0;
    #1 chk("R4", "abort_low", abort_o, 0);
    wr(3'd0, 32'h83);
    #1 chk("R4", "no_abort_on_start", abort_o, 0);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule